// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block watches the digital output of an analog comparator and turns selected transitions of it into a sticky event flag and an interrupt request. The comparator level is brought into the clock domain through a synchronizer chain. Each synchronized sample is compared with the one taken a cycle earlier to find rising and falling transitions. A two-bit mode field chooses which transitions count: any change, only falling, or only rising. The fourth code is reserved and never produces an event.

Software reaches the block through a single five-bit control word. The word holds the mode field, a capture-route bit, an interrupt enable and the event flag. The flag clears in two ways: a write with a one in the flag position, or the interrupt vector acknowledge strobe from the CPU. The capture-route bit passes the synchronized comparator level on to a timer's capture front end. When the bit is clear, that output stays low. All pins are plain level or strobe signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset the control word reads all zero (mode 00, route 0, enable 0, flag 0), and `irq` and `cap_trig` are low. The comparator level present when reset is released is taken as the starting sample and raises no event, whatever that level is.
- R2: With mode 00, every change of the comparator level sets the flag. The flag becomes visible on the third rising clock edge after the input changes: two synchronizer stages, then the flag register.
- R3: With mode 10, a falling transition (1 to 0) sets the flag and a rising transition does not.
- R4: With mode 11, a rising transition (0 to 1) sets the flag and a falling transition does not.
- R5: With mode 01 (reserved), no transition ever sets the flag.
- R6: `irq` is high exactly when the flag, the interrupt enable (word bit 3) and `gie` are all one.
- R7: A `vec_ack` pulse clears the flag on the next clock edge.
- R8: A write with bit 4 set clears the flag. A write with bit 4 clear leaves the flag unchanged. Bits 1:0 of the write set the mode, bit 2 sets the route and bit 3 sets the enable.
- R9: When a selected event and a clear (by write or by acknowledge) fall in the same cycle, the flag ends up set.
- R10: With the route bit (bit 2) at one, `cap_trig` follows the synchronized comparator level: it changes on the second rising edge after the input changes. With the route bit at zero, `cap_trig` is low.
- R11: After the mode field is rewritten, a transition that matches the new mode sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 1 | Asynchronous comparator output level |
| gie | input | 1 | Global interrupt enable from the CPU |
| vec_ack | input | 1 | Interrupt vector acknowledge strobe; clears the flag |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 5 | Write data: [1:0] mode, [2] route, [3] enable, [4] write one to clear the flag |
| rd_data | output | 5 | Read data: [1:0] mode, [2] route, [3] enable, [4] flag |
| irq | output | 1 | Interrupt request |
| flag | output | 1 | Event flag |
| cap_trig | output | 1 | Capture trigger to the timer front end |

## Verification
On every cycle, the assertions check the gating of `irq` by the flag, the enable and `gie`. They also check that the reserved mode never sets the flag, that a detected event always leaves the flag set even when a clear arrives with it, that clears work when no event competes, that a write of zero keeps the flag, and that `cap_trig` stays low while routing is off. Only the directed scenarios can show the rest:
- which transitions each mode selects;
- the exact three-edge latency from the input to the flag;
- the priming of the starting sample after reset;
- the two-edge delay of `cap_trig`;
- that an edge arriving right after a mode rewrite is caught.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } cmp_mode_e;

  localparam int unsigned CTRL_W    = 5;
  localparam int unsigned BIT_ROUTE = 2;
  localparam int unsigned BIT_IE    = 3;
  localparam int unsigned BIT_FLAG  = 4;

  typedef struct packed {
    logic      flag;
    logic      ie;
    logic      route;
    cmp_mode_e mode;
  } ctrl_word_t;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic cur,
  output logic prev,
  output logic primed
);
  localparam int unsigned CW   = $clog2(STAGES + 2);
  localparam logic [CW-1:0] FULL = CW'(STAGES + 1);

  logic [STAGES-1:0] chain;
  logic [CW-1:0]     fill;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      fill <= '0;
    end else begin
      prev <= cur;
      if (fill != FULL) fill <= fill + 1'b1;
    end
  end

  assign primed = (fill == FULL);

endmodule

// File: rtl/cmp_edge_sel.sv
module cmp_edge_sel
  import cmp_evt_pkg::*;
(
  input  logic      cur,
  input  logic      prev,
  input  logic      primed,
  input  cmp_mode_e mode,
  output logic      hit
);
  logic rise, fall;

  always_comb begin
    rise = cur & ~prev;
    fall = ~cur & prev;
    unique case (mode)
      MODE_TOGGLE: hit = primed & (rise | fall);
      MODE_FALL:   hit = primed & fall;
      MODE_RISE:   hit = primed & rise;
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
  import cmp_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              vec_ack,
  input  logic              hit,
  output ctrl_word_t        ctrl
);
  logic clr;

  assign clr = vec_ack | (wr_en & wr_data[BIT_FLAG]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_en) begin
        ctrl.mode  <= cmp_mode_e'(wr_data[1:0]);
        ctrl.route <= wr_data[BIT_ROUTE];
        ctrl.ie    <= wr_data[BIT_IE];
      end
      if (hit)      ctrl.flag <= 1'b1;
      else if (clr) ctrl.flag <= 1'b0;
    end
  end

endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_in,
  input  logic              gie,
  input  logic              vec_ack,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              irq,
  output logic              flag,
  output logic              cap_trig
);
  logic       s_cur, s_prev, s_primed;
  logic       ev_hit;
  ctrl_word_t ctrl;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cmp_in),
    .cur(s_cur), .prev(s_prev), .primed(s_primed)
  );

  cmp_edge_sel u_sel (
    .cur(s_cur), .prev(s_prev), .primed(s_primed),
    .mode(ctrl.mode), .hit(ev_hit)
  );

  cmp_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .vec_ack(vec_ack), .hit(ev_hit), .ctrl(ctrl)
  );

  assign rd_data  = ctrl;
  assign flag     = ctrl.flag;
  assign irq      = ctrl.flag & ctrl.ie & gie;
  assign cap_trig = ctrl.route & s_cur;

endmodule

// File: rtl/cmp_evt_ctrl_chk.sv
module cmp_evt_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic       vec_ack,
  input logic       wr_en,
  input logic [4:0] wr_data,
  input logic [4:0] rd_data,
  input logic       hit,
  input logic       flag,
  input logic       irq,
  input logic       cap_trig
);
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (gie && flag && rd_data[3])); // R6
  AST_IRQ_GIE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !gie |-> !irq); // R6
  AST_RSVD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) hit |-> (rd_data[1:0] != 2'b01)); // R5
  AST_RSVD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> ($past(rd_data[1:0]) != 2'b01)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) hit |=> flag); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (vec_ack && !hit) |=> !flag); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_data[4] && !hit) |=> !flag); // R8
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) (flag && !vec_ack && !(wr_en && wr_data[4])) |=> flag); // R8
  AST_ROUTE_OFF: assert property (@(posedge clk) disable iff (!rst_n) !rd_data[2] |-> !cap_trig); // R10
endmodule

bind cmp_evt_ctrl cmp_evt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .vec_ack(vec_ack),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .hit(ev_hit), .flag(flag), .irq(irq), .cap_trig(cap_trig)
);

// File: tb/cmp_evt_ctrl_test.sv
`timescale 1ns/1ps
module cmp_evt_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_in = 1'b1;
  logic       gie = 1'b0;
  logic       vec_ack = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] rd_data;
  logic       irq, flag, cap_trig;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  cmp_evt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .gie(gie), .vec_ack(vec_ack),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq(irq), .flag(flag), .cap_trig(cap_trig)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] cw(input logic [1:0] m, input logic rt,
                                    input logic ie, input logic clr);
    return {clr, ie, rt, m};
  endfunction

  task automatic wr(input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic drive(input logic v);
    @(negedge clk);
    cmp_in = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (8) @(negedge clk);
    chk("R1 ctrl word", 8'(rd_data), 8'h00);
    chk("R1 flag no start event", 8'(flag), 8'h0);
    chk("R1 irq", 8'(irq), 8'h0);
    chk("R1 cap_trig", 8'(cap_trig), 8'h0);
  endtask

  task automatic t_toggle;
    gie = 1'b1;
    wr(cw(2'b00, 1'b0, 1'b1, 1'b0));
    @(negedge clk); cmp_in = 1'b0;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R2 not yet after two edges", 8'(flag), 8'h0);
    @(posedge clk); @(negedge clk);
    chk("R2 fall sets flag on third edge", 8'(flag), 8'h1);
    chk("R6 irq with all three", 8'(irq), 8'h1);
    gie = 1'b0; #1;
    chk("R6 irq low without gie", 8'(irq), 8'h0);
    gie = 1'b1;
    wr(cw(2'b00, 1'b0, 1'b1, 1'b1));
    chk("R8 write one clears", 8'(flag), 8'h0);
    drive(1'b1);
    chk("R2 rise sets flag", 8'(flag), 8'h1);
    @(negedge clk); vec_ack = 1'b1; @(negedge clk); vec_ack = 1'b0;
    chk("R7 ack clears", 8'(flag), 8'h0);
  endtask

  task automatic t_ie_off;
    wr(cw(2'b00, 1'b0, 1'b0, 1'b1));
    drive(1'b0);
    chk("R6 flag set with enable off", 8'(flag), 8'h1);
    chk("R6 irq low with enable off", 8'(irq), 8'h0);
    wr(cw(2'b00, 1'b0, 1'b0, 1'b0));
    chk("R8 write zero keeps flag", 8'(flag), 8'h1);
    chk("R8 fields read back", 8'(rd_data), 8'h10);
    wr(cw(2'b00, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_fall;
    wr(cw(2'b10, 1'b0, 1'b1, 1'b1));
    drive(1'b1);
    chk("R3 rise ignored in fall mode", 8'(flag), 8'h0);
    drive(1'b0);
    chk("R3 fall sets flag", 8'(flag), 8'h1);
  endtask

  task automatic t_rise;
    wr(cw(2'b11, 1'b0, 1'b1, 1'b1));
    chk("R8 clear before rise test", 8'(flag), 8'h0);
    drive(1'b1);
    chk("R4 rise sets flag", 8'(flag), 8'h1);
    wr(cw(2'b11, 1'b0, 1'b1, 1'b1));
    drive(1'b0);
    chk("R4 fall ignored in rise mode", 8'(flag), 8'h0);
  endtask

  task automatic t_rsvd;
    wr(cw(2'b01, 1'b0, 1'b1, 1'b1));
    drive(1'b1);
    drive(1'b0);
    drive(1'b1);
    chk("R5 reserved mode never sets", 8'(flag), 8'h0);
    chk("R5 irq stays low", 8'(irq), 8'h0);
  endtask

  task automatic t_setwins;
    wr(cw(2'b00, 1'b0, 1'b1, 1'b1));
    @(negedge clk); cmp_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = cw(2'b00, 1'b0, 1'b1, 1'b1);
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R9 event beats write clear", 8'(flag), 8'h1);
    wr(cw(2'b00, 1'b0, 1'b1, 1'b1));
    @(negedge clk); cmp_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); vec_ack = 1'b1;
    @(negedge clk); vec_ack = 1'b0;
    chk("R9 event beats ack clear", 8'(flag), 8'h1);
  endtask

  task automatic t_capture;
    wr(cw(2'b00, 1'b1, 1'b0, 1'b1));
    chk("R10 route on follows level", 8'(cap_trig), 8'h1);
    @(negedge clk); cmp_in = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 unchanged after one edge", 8'(cap_trig), 8'h1);
    @(posedge clk); @(negedge clk);
    chk("R10 follows after two edges", 8'(cap_trig), 8'h0);
    drive(1'b1);
    chk("R10 high again", 8'(cap_trig), 8'h1);
    wr(cw(2'b00, 1'b0, 1'b0, 1'b1));
    chk("R10 route off holds low", 8'(cap_trig), 8'h0);
  endtask

  task automatic t_modechg;
    wr(cw(2'b11, 1'b0, 1'b1, 1'b1));
    drive(1'b0);
    wr(cw(2'b10, 1'b0, 1'b1, 1'b1));
    drive(1'b1);
    wr(cw(2'b11, 1'b0, 1'b1, 1'b1));
    chk("R11 cleared before new mode edge", 8'(flag), 8'h0);
    drive(1'b0);
    chk("R11 fall ignored under rise mode", 8'(flag), 8'h0);
    wr(cw(2'b10, 1'b0, 1'b1, 1'b0));
    drive(1'b1);
    chk("R11 rise ignored under new fall mode", 8'(flag), 8'h0);
    drive(1'b0);
    chk("R11 fall caught after rewrite", 8'(flag), 8'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_toggle();
    t_ie_off();
    t_fall();
    t_rise();
    t_rsvd();
    t_setwins();
    t_capture();
    t_modechg();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule